// File: doc/BRIEF.md
# SD Card Clock Generator

This block derives the clock sent to an SD or SDIO card from the host's kernel clock. A control word selects how the clock is made. It can be divided by a programmable ratio, or the kernel clock can be passed straight through. The word also sets whether the clock runs at all and which edge of the kernel clock launches the card clock transitions. Two independent conditions can pause the clock: an idle bus, and a data FIFO that is about to run dry or overflow. Flow control therefore stalls the card instead of losing data.

In divided mode the ratio is the 9-bit divider value plus two. The divider value is assembled from a one-bit upper part and an eight-bit lower part. Every start and stop happens at a period boundary, while the card clock is low, so a pause never produces a runt pulse. Two companion outputs mark the kernel cycles that start a high phase and a low phase. The command and data engines use them to time their shifting. The bus-width code is carried through unchanged for the data path.

Top module: `sdclk_gen`

## Requirements
- R1: While reset is active and right after it is released with the clock disabled, card_clk, clk_rise_pulse and clk_fall_pulse are all 0.
- R2: With bypass off, each period lasts D+2 kernel cycles, where D = {ctl_div_hi, ctl_div_lo}. A period is ceil((D+2)/2) cycles high followed by floor((D+2)/2) cycles low.
- R3: When ctl_enable is 1 at a kernel rising edge where the clock is stopped, card_clk is high in the following cycle. When ctl_enable is 0, the clock completes its current period and then stays low.
- R4: With ctl_bypass = 1 and the clock enabled, card_clk equals the kernel clock, high during its high half, and D is ignored. After the clock is disabled, card_clk stays 0.
- R5: With ctl_fall_edge = 1, divided card_clk transitions are launched by the kernel falling edge, half a kernel cycle after the rising-edge timing.
- R6: With ctl_idle_stop = 1, the clock is stopped while bus_idle = 1. With ctl_idle_stop = 0, bus_idle has no effect.
- R7: With ctl_flow_stop = 1, the clock is stopped while fifo_near_empty or fifo_near_full is 1. With ctl_flow_stop = 0, those flags have no effect.
- R8: Stopping only takes effect after a full low phase. A stop request during a high phase lets that high phase and the following low phase complete.
- R9: A new D value applied mid-period leaves the current period at its old length. The new ratio applies from the next period.
- R10: In divided mode, clk_rise_pulse is 1 in the first cycle of each high phase and clk_fall_pulse is 1 in the first cycle of each low phase. In bypass mode, both pulses are 1 in every cycle the clock runs. Neither pulse is asserted while the clock is stopped.
- R11: bus_mode_o repeats ctl_bus_mode: 00 = 1-bit, 01 = 4-bit, 10 = 8-bit, 11 = reserved, passed unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_k | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_enable | input | 1 | Card clock enable |
| ctl_bypass | input | 1 | Pass kernel clock straight through |
| ctl_fall_edge | input | 1 | 1: launch transitions on the kernel falling edge |
| ctl_idle_stop | input | 1 | Stop the clock while the bus is idle |
| ctl_flow_stop | input | 1 | Stop the clock on FIFO near-empty or near-full |
| ctl_div_hi | input | 1 | Upper part of the divider value |
| ctl_div_lo | input | 8 | Lower part of the divider value |
| ctl_bus_mode | input | 2 | Bus width code |
| bus_idle | input | 1 | Bus has no transfer in progress |
| fifo_near_empty | input | 1 | Data FIFO close to underrun |
| fifo_near_full | input | 1 | Data FIFO close to overrun |
| card_clk | output | 1 | Clock to the card |
| clk_rise_pulse | output | 1 | First kernel cycle of a high phase |
| clk_fall_pulse | output | 1 | First kernel cycle of a low phase |
| bus_mode_o | output | 2 | Bus width code, passed through |

## Verification
In divided mode, a gating condition sampled at a kernel rising edge shows on card_clk and the pulses in the cycle that edge starts. The bench therefore applies stimulus 15 ns after an edge and reads results 15 ns after the next one. With ctl_fall_edge set, card_clk follows half a cycle later. The bench reads it both 5 ns and 15 ns after each rising edge, and expects the old level first and the new level second. In bypass mode, the enable passes a rising-edge register and then a falling-edge register before the clock appears. The first high half is due two rising edges after the enable is applied, and the bench checks it 5 ns into that high half and again at 15 ns.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

   typedef enum logic [1:0] {
      BW_ONE  = 2'b00,
      BW_FOUR = 2'b01,
      BW_EIGHT = 2'b10,
      BW_RSVD = 2'b11
   } bus_width_e;

   // number of high cycles for a ratio: ceil(ratio/2)
   function automatic int unsigned high_len(input int unsigned ratio);
      return (ratio + 1) / 2;
   endfunction

endpackage

// File: rtl/sdclk_gate.sv
module sdclk_gate #(
   parameter bit FLOW_CTRL_EN = 1'b1
) (
   input  logic enable,
   input  logic idle_stop,
   input  logic bus_idle,
   input  logic flow_stop,
   input  logic near_empty,
   input  logic near_full,
   output logic gate_ok
);

   logic idle_block;
   logic flow_block;

   assign idle_block = idle_stop & bus_idle;

   generate
      if (FLOW_CTRL_EN) begin : g_flow
         assign flow_block = flow_stop & (near_empty | near_full);
      end else begin : g_noflow
         logic unused_flow;
         assign unused_flow = flow_stop ^ near_empty ^ near_full;
         assign flow_block = 1'b0;
      end
   endgenerate

   assign gate_ok = enable & ~idle_block & ~flow_block;

endmodule

// File: rtl/sdclk_divider.sv
module sdclk_divider #(
   parameter int unsigned DIV_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_req,
   input  logic [DIV_W-1:0] div_val,
   output logic             div_q,
   output logic             rise_q,
   output logic             fall_q
);

   localparam int unsigned CNT_W = DIV_W + 1;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnt_nx;
   logic [CNT_W-1:0] ratio_q;
   logic [CNT_W-1:0] hi_q;
   logic [CNT_W-1:0] new_ratio;
   logic [CNT_W-1:0] new_hi;
   logic             running;
   logic             at_end;

   assign new_ratio = {1'b0, div_val} + CNT_W'(2);
   assign new_hi    = CNT_W'((new_ratio + CNT_W'(1)) >> 1);
   assign cnt_nx    = cnt + CNT_W'(1);
   assign at_end    = !running || (cnt == ratio_q - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         ratio_q <= CNT_W'(2);
         hi_q    <= CNT_W'(1);
         running <= 1'b0;
         div_q   <= 1'b0;
         rise_q  <= 1'b0;
         fall_q  <= 1'b0;
      end else if (at_end) begin
         cnt    <= '0;
         fall_q <= 1'b0;
         if (run_req) begin
            running <= 1'b1;
            ratio_q <= new_ratio;
            hi_q    <= new_hi;
            div_q   <= 1'b1;
            rise_q  <= 1'b1;
         end else begin
            running <= 1'b0;
            div_q   <= 1'b0;
            rise_q  <= 1'b0;
         end
      end else begin
         cnt    <= cnt_nx;
         div_q  <= (cnt_nx < hi_q);
         rise_q <= 1'b0;
         fall_q <= (cnt_nx == hi_q);
      end
   end

endmodule

// File: rtl/sdclk_outstage.sv
module sdclk_outstage #(
   parameter bit EDGE_SEL_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bypass,
   input  logic fall_edge,
   input  logic byp_req,
   input  logic div_q,
   input  logic div_rise,
   input  logic div_fall,
   output logic card_clk,
   output logic rise_pulse,
   output logic fall_pulse
);

   logic byp_p;
   logic byp_n;
   logic byp_pulse;
   logic div_n;
   logic sel_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byp_p     <= 1'b0;
         byp_pulse <= 1'b0;
      end else begin
         byp_p     <= byp_req;
         byp_pulse <= byp_n;
      end
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byp_n <= 1'b0;
         div_n <= 1'b0;
      end else begin
         byp_n <= byp_p;
         div_n <= div_q;
      end
   end

   generate
      if (EDGE_SEL_EN) begin : g_edge
         assign sel_fall = fall_edge;
      end else begin : g_noedge
         logic unused_edge;
         assign unused_edge = fall_edge;
         assign sel_fall = 1'b0;
      end
   endgenerate

   always_comb begin
      if (bypass) begin
         card_clk   = sel_fall ? (~clk & byp_p) : (clk & byp_n);
         rise_pulse = byp_pulse;
         fall_pulse = byp_pulse;
      end else begin
         card_clk   = sel_fall ? div_n : div_q;
         rise_pulse = div_rise;
         fall_pulse = div_fall;
      end
   end

endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen #(
   parameter int unsigned DIV_LO_W     = 8,
   parameter int unsigned DIV_HI_W     = 1,
   parameter bit          EDGE_SEL_EN  = 1'b1,
   parameter bit          FLOW_CTRL_EN = 1'b1
) (
   input  logic                clk_k,
   input  logic                rst_n,
   input  logic                ctl_enable,
   input  logic                ctl_bypass,
   input  logic                ctl_fall_edge,
   input  logic                ctl_idle_stop,
   input  logic                ctl_flow_stop,
   input  logic [DIV_HI_W-1:0] ctl_div_hi,
   input  logic [DIV_LO_W-1:0] ctl_div_lo,
   input  logic [1:0]          ctl_bus_mode,
   input  logic                bus_idle,
   input  logic                fifo_near_empty,
   input  logic                fifo_near_full,
   output logic                card_clk,
   output logic                clk_rise_pulse,
   output logic                clk_fall_pulse,
   output logic [1:0]          bus_mode_o
);

   import sdclk_pkg::*;

   localparam int unsigned DIV_W = DIV_LO_W + DIV_HI_W;

   generate
      if (DIV_LO_W < 1 || DIV_HI_W < 1) begin : g_bad_width
         $error("sdclk_gen: divider fields need at least one bit each");
      end
      if (DIV_W > 24) begin : g_too_wide
         $error("sdclk_gen: divider wider than 24 bits is not supported");
      end
   endgenerate

   logic             gate_ok;
   logic [DIV_W-1:0] div_val;
   logic             div_q;
   logic             div_rise;
   logic             div_fall;
   bus_width_e       bw;

   assign div_val = {ctl_div_hi, ctl_div_lo};

   sdclk_gate #(
      .FLOW_CTRL_EN(FLOW_CTRL_EN)
   ) u_gate (
      .enable     (ctl_enable),
      .idle_stop  (ctl_idle_stop),
      .bus_idle   (bus_idle),
      .flow_stop  (ctl_flow_stop),
      .near_empty (fifo_near_empty),
      .near_full  (fifo_near_full),
      .gate_ok    (gate_ok)
   );

   sdclk_divider #(
      .DIV_W(DIV_W)
   ) u_div (
      .clk     (clk_k),
      .rst_n   (rst_n),
      .run_req (gate_ok & ~ctl_bypass),
      .div_val (div_val),
      .div_q   (div_q),
      .rise_q  (div_rise),
      .fall_q  (div_fall)
   );

   sdclk_outstage #(
      .EDGE_SEL_EN(EDGE_SEL_EN)
   ) u_out (
      .clk        (clk_k),
      .rst_n      (rst_n),
      .bypass     (ctl_bypass),
      .fall_edge  (ctl_fall_edge),
      .byp_req    (gate_ok & ctl_bypass),
      .div_q      (div_q),
      .div_rise   (div_rise),
      .div_fall   (div_fall),
      .card_clk   (card_clk),
      .rise_pulse (clk_rise_pulse),
      .fall_pulse (clk_fall_pulse)
   );

   assign bw         = bus_width_e'(ctl_bus_mode);
   assign bus_mode_o = bw;

endmodule

// File: rtl/sdclk_gen_chk.sv
module sdclk_gen_chk (
   input logic clk_k,
   input logic rst_n,
   input logic ctl_enable,
   input logic ctl_bypass,
   input logic ctl_idle_stop,
   input logic ctl_flow_stop,
   input logic bus_idle,
   input logic fifo_near_empty,
   input logic fifo_near_full,
   input logic div_q,
   input logic clk_rise_pulse,
   input logic clk_fall_pulse
);

   logic gate_now;
   assign gate_now = ctl_enable
                   & ~(ctl_idle_stop & bus_idle)
                   & ~(ctl_flow_stop & (fifo_near_empty | fifo_near_full));

   // R10: a rise pulse marks a cycle in which the divided clock is high
   assert_rise_in_high_R10: assert property (@(posedge clk_k) disable iff (!rst_n)
      (!ctl_bypass && clk_rise_pulse) |-> div_q);

   // R2: a rise pulse follows a low cycle
   assert_rise_after_low_R2: assert property (@(posedge clk_k) disable iff (!rst_n)
      (!ctl_bypass && !$past(ctl_bypass) && clk_rise_pulse) |-> !$past(div_q));

   // R10: a fall pulse marks the first low cycle after a high one
   assert_fall_edge_R10: assert property (@(posedge clk_k) disable iff (!rst_n)
      (!ctl_bypass && clk_fall_pulse) |-> (!div_q && $past(div_q)));

   // R6 / R7: no new high phase starts while the gate is closed
   assert_gate_closed_R6: assert property (@(posedge clk_k) disable iff (!rst_n)
      (!ctl_bypass && !gate_now) |=> (ctl_bypass || !clk_rise_pulse));

   // R8: a started high phase is never followed at once by another rise
   assert_single_rise_R8: assert property (@(posedge clk_k) disable iff (!rst_n)
      (!ctl_bypass && clk_rise_pulse) |=> (ctl_bypass || !clk_rise_pulse));

endmodule

bind sdclk_gen sdclk_gen_chk u_chk (
   .clk_k           (clk_k),
   .rst_n           (rst_n),
   .ctl_enable      (ctl_enable),
   .ctl_bypass      (ctl_bypass),
   .ctl_idle_stop   (ctl_idle_stop),
   .ctl_flow_stop   (ctl_flow_stop),
   .bus_idle        (bus_idle),
   .fifo_near_empty (fifo_near_empty),
   .fifo_near_full  (fifo_near_full),
   .div_q           (div_q),
   .clk_rise_pulse  (clk_rise_pulse),
   .clk_fall_pulse  (clk_fall_pulse)
);

// File: tb/sdclk_gen_bench.sv
module sdclk_gen_bench;

   logic       clk_k = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctl_enable = 1'b0;
   logic       ctl_bypass = 1'b0;
   logic       ctl_fall_edge = 1'b0;
   logic       ctl_idle_stop = 1'b0;
   logic       ctl_flow_stop = 1'b0;
   logic [0:0] ctl_div_hi = '0;
   logic [7:0] ctl_div_lo = '0;
   logic [1:0] ctl_bus_mode = '0;
   logic       bus_idle = 1'b0;
   logic       fifo_near_empty = 1'b0;
   logic       fifo_near_full = 1'b0;
   logic       card_clk;
   logic       clk_rise_pulse;
   logic       clk_fall_pulse;
   logic [1:0] bus_mode_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk_k = ~clk_k;

   sdclk_gen u_sdclk_gen (
      .clk_k           (clk_k),
      .rst_n           (rst_n),
      .ctl_enable      (ctl_enable),
      .ctl_bypass      (ctl_bypass),
      .ctl_fall_edge   (ctl_fall_edge),
      .ctl_idle_stop   (ctl_idle_stop),
      .ctl_flow_stop   (ctl_flow_stop),
      .ctl_div_hi      (ctl_div_hi),
      .ctl_div_lo      (ctl_div_lo),
      .ctl_bus_mode    (ctl_bus_mode),
      .bus_idle        (bus_idle),
      .fifo_near_empty (fifo_near_empty),
      .fifo_near_full  (fifo_near_full),
      .card_clk        (card_clk),
      .clk_rise_pulse  (clk_rise_pulse),
      .clk_fall_pulse  (clk_fall_pulse),
      .bus_mode_o      (bus_mode_o)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic int pat(input int r, input int k);
      return ((k % r) < ((r + 1) / 2)) ? 1 : 0;
   endfunction

   task automatic step();
      @(posedge clk_k);
      #15;
   endtask

   task automatic set_div(input int d);
      ctl_div_hi = 1'(d >> 8);
      ctl_div_lo = 8'(d);
   endtask

   task automatic expect_run(input int r, input int n, input string req);
      for (int k = 0; k < r * n; k++) begin
         step();
         chk(req, "card_clk", int'(card_clk), pat(r, k));
         chk(req, "rise", int'(clk_rise_pulse), ((k % r) == 0) ? 1 : 0);
         chk(req, "fall", int'(clk_fall_pulse), ((k % r) == (r + 1) / 2) ? 1 : 0);
      end
   endtask

   task automatic expect_quiet(input int n, input string req);
      for (int k = 0; k < n; k++) begin
         step();
         chk(req, "card_clk stopped", int'(card_clk), 0);
         chk(req, "no rise pulse", int'(clk_rise_pulse), 0);
         chk(req, "no fall pulse", int'(clk_fall_pulse), 0);
      end
   endtask

   task automatic t_reset();
      #5;
      chk("R1", "card_clk in reset", int'(card_clk), 0);
      chk("R1", "rise in reset", int'(clk_rise_pulse), 0);
      repeat (3) @(posedge clk_k);
      #15;
      rst_n = 1'b1;
      expect_quiet(3, "R1");
   endtask

   task automatic t_ratio(input int d);
      set_div(d);
      ctl_enable = 1'b1;
      expect_run(d + 2, 2, "R2");
      ctl_enable = 1'b0;
      expect_quiet(d + 4, "R3");
   endtask

   task automatic t_stop_mid();
      set_div(5);
      ctl_enable = 1'b1;
      step();
      chk("R3", "start high", int'(card_clk), 1);
      ctl_enable = 1'b0;
      for (int k = 1; k < 7; k++) begin
         step();
         chk("R8", "period completes", int'(card_clk), pat(7, k));
      end
      expect_quiet(10, "R8");
   endtask

   task automatic t_idle();
      set_div(0);
      ctl_idle_stop = 1'b1;
      bus_idle = 1'b1;
      ctl_enable = 1'b1;
      expect_quiet(6, "R6");
      bus_idle = 1'b0;
      expect_run(2, 2, "R6");
      bus_idle = 1'b1;
      expect_quiet(4, "R6");
      ctl_idle_stop = 1'b0;
      expect_run(2, 1, "R6");
      ctl_enable = 1'b0;
      bus_idle = 1'b0;
      expect_quiet(3, "R6");
   endtask

   task automatic t_flow();
      set_div(1);
      ctl_flow_stop = 1'b1;
      fifo_near_full = 1'b1;
      ctl_enable = 1'b1;
      expect_quiet(5, "R7");
      fifo_near_full = 1'b0;
      fifo_near_empty = 1'b1;
      expect_quiet(5, "R7");
      fifo_near_empty = 1'b0;
      expect_run(3, 1, "R7");
      fifo_near_full = 1'b1;
      ctl_flow_stop = 1'b0;
      expect_run(3, 1, "R7");
      ctl_enable = 1'b0;
      fifo_near_full = 1'b0;
      expect_quiet(4, "R7");
   endtask

   task automatic t_divchange();
      set_div(1);
      ctl_enable = 1'b1;
      step();
      chk("R9", "old period high", int'(card_clk), 1);
      set_div(3);
      step();
      chk("R9", "old period second high", int'(card_clk), 1);
      step();
      chk("R9", "old period low", int'(card_clk), 0);
      chk("R9", "old period fall", int'(clk_fall_pulse), 1);
      expect_run(5, 1, "R9");
      ctl_enable = 1'b0;
      expect_quiet(6, "R9");
   endtask

   task automatic t_bypass();
      set_div(3);
      ctl_bypass = 1'b1;
      ctl_enable = 1'b1;
      step();
      for (int k = 0; k < 4; k++) begin
         @(posedge clk_k);
         #5;
         chk("R4", "bypass high half", int'(card_clk), 1);
         chk("R10", "bypass rise pulse", int'(clk_rise_pulse), 1);
         chk("R10", "bypass fall pulse", int'(clk_fall_pulse), 1);
         #10;
         chk("R4", "bypass low half", int'(card_clk), 0);
      end
      ctl_enable = 1'b0;
      @(posedge clk_k);
      #5;
      for (int k = 0; k < 3; k++) begin
         @(posedge clk_k);
         #5;
         chk("R4", "bypass stopped", int'(card_clk), 0);
         chk("R10", "bypass no pulse", int'(clk_rise_pulse), 0);
      end
      ctl_bypass = 1'b0;
      expect_quiet(2, "R4");
   endtask

   task automatic t_edge();
      set_div(2);
      ctl_fall_edge = 1'b1;
      ctl_enable = 1'b1;
      for (int k = 0; k < 8; k++) begin
         @(posedge clk_k);
         #5;
         chk("R5", "before kernel fall", int'(card_clk), (k == 0) ? 0 : pat(4, k - 1));
         #10;
         chk("R5", "after kernel fall", int'(card_clk), pat(4, k));
      end
      ctl_enable = 1'b0;
      expect_quiet(6, "R5");
      ctl_fall_edge = 1'b0;
   endtask

   task automatic t_busmode();
      for (int m = 0; m < 4; m++) begin
         ctl_bus_mode = 2'(m);
         step();
         chk("R11", "bus mode passthrough", int'(bus_mode_o), m);
      end
   endtask

   initial begin
      t_reset();
      t_ratio(0);
      t_ratio(1);
      t_ratio(5);
      t_ratio(256);
      t_stop_mid();
      t_idle();
      t_flow();
      t_divchange();
      t_bypass();
      t_edge();
      t_busmode();
      if (!done) begin
         done = 1'b1;
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk_k);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule